// File: doc/BRIEF.md
# Programmable Raster Sync Generator

This block produces the horizontal sync, vertical sync and data-enable strobes for a raster display. It also produces a 16-bit pixel bus, all from two counters in the pixel-clock domain. Eight timing fields describe the frame: a total, a sync width, an active-start position and an active-end position for each axis. The active positions are absolute counter values measured from the start of sync, so each one already includes the sync width and back porch. With the 1080p settings the line is 2200 clocks and the frame is 1125 lines.

Generation begins only when the run enable goes from 0 to 1. During active video the block raises a request strobe toward an upstream pixel stream and forwards the streamed word when it is valid, or zero when it is not. A second enable, also acted on when it goes from 0 to 1, switches to a constant-colour mode. In that mode every active pixel carries the colour input and nothing is requested from the stream. The timing fields are captured into shadow registers only at the start of a frame, so the raster never changes part-way through a frame.

Top module: `vid_timing_gen`

## Requirements
- R1: The horizontal counter runs from 0 to line total minus 1 and then wraps, so each line lasts exactly line-total clocks and hsync rises only at count 0.
- R2: hsync is high while the horizontal count is below the horizontal sync width.
- R3: The vertical counter advances once per line, in the cycle the horizontal counter wraps, and wraps after frame-total lines; vsync is high while the vertical count is below the vertical sync width.
- R4: de is high exactly when the horizontal count lies in [h-start, h-end) and the vertical count lies in [v-start, v-end).
- R5: Output starts only on a 0-to-1 change of run_en, with both counters at 0 in the first cycle after that edge. A run_en held high through reset starts nothing. While run_en is low, hsync, vsync, de, s_req and pix are all 0.
- R6: A 0-to-1 change of pat_en selects colour mode, in which pix equals pat_color on every active pixel and s_req stays 0. A pat_en level held from reset has no effect.
- R7: In stream mode s_req equals de, and pix is s_data when de and s_valid are both high, otherwise 0.
- R8: The timing fields are sampled at the start edge and at the last clock of each frame. A field changed mid-frame takes effect from the next frame.
- R9: With the 1080p fields (2200, 44, 192, 2112, 1125, 5, 41, 1121), vsync covers lines 0 to 4 and no pixel is active before line 41. The first active pixel is at column 192 of line 41.
- R10: When pat_en goes low, the next clock returns to stream mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Run enable, acted on at its rising change |
| pat_en | input | 1 | Colour-mode enable, acted on at its rising change |
| pat_color | input | PW | Constant colour for colour mode |
| cfg_htot | input | CW | Clocks per line |
| cfg_hsw | input | CW | Horizontal sync width |
| cfg_hmin | input | CW | First active column |
| cfg_hmax | input | CW | Column after the last active one |
| cfg_vtot | input | CW | Lines per frame |
| cfg_vsw | input | CW | Vertical sync width in lines |
| cfg_vmin | input | CW | First active line |
| cfg_vmax | input | CW | Line after the last active one |
| s_data | input | PW | Upstream pixel word |
| s_valid | input | 1 | Upstream word is valid |
| s_req | output | 1 | Pixel request toward the stream |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix | output | PW | Pixel output |

## Verification
The counters reach 0,0 at the clock edge that sees run_en rise, so the first raster position is due one cycle after the enable change. Every later position is due one cycle after the previous one. hsync, vsync, de, s_req and pix decode the counters and the stream inputs without further registers, so they are compared in the same low clock phase in which s_data and s_valid are driven. The bench keeps its own counters and steps them once per clock. It loads its own copy of the timing fields at the same frame boundary the design uses, which places a mid-frame field change exactly one frame late. Mode changes on pat_en and run_en are made after a check and before the next edge, and they are expected at the following check.

// File: rtl/vid_timing_gen.sv
`timescale 1ns/1ps
module vid_timing_gen #(
  parameter int CW       = 12,
  parameter int PW       = 16,
  parameter int DEF_HTOT = 2200,
  parameter int DEF_HSW  = 44,
  parameter int DEF_HMIN = 192,
  parameter int DEF_HMAX = 2112,
  parameter int DEF_VTOT = 1125,
  parameter int DEF_VSW  = 5,
  parameter int DEF_VMIN = 41,
  parameter int DEF_VMAX = 1121
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_en,
  input  logic          pat_en,
  input  logic [PW-1:0] pat_color,
  input  logic [CW-1:0] cfg_htot,
  input  logic [CW-1:0] cfg_hsw,
  input  logic [CW-1:0] cfg_hmin,
  input  logic [CW-1:0] cfg_hmax,
  input  logic [CW-1:0] cfg_vtot,
  input  logic [CW-1:0] cfg_vsw,
  input  logic [CW-1:0] cfg_vmin,
  input  logic [CW-1:0] cfg_vmax,
  input  logic [PW-1:0] s_data,
  input  logic          s_valid,
  output logic          s_req,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [PW-1:0] pix
);

  logic          run_q, pat_q, active, pat_mode;
  logic [CW-1:0] hc, vc;
  logic [CW-1:0] sh_htot, sh_hsw, sh_hmin, sh_hmax;
  logic [CW-1:0] sh_vtot, sh_vsw, sh_vmin, sh_vmax;

  wire start     = run_en & ~run_q;
  wire line_end  = hc == sh_htot - CW'(1);
  wire last_line = vc == sh_vtot - CW'(1);
  wire load      = run_en & (start | (active & line_end & last_line));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b1;
      pat_q    <= 1'b1;
      active   <= 1'b0;
      pat_mode <= 1'b0;
      hc       <= '0;
      vc       <= '0;
    end else begin
      run_q    <= run_en;
      pat_q    <= pat_en;
      pat_mode <= pat_en & (pat_mode | ~pat_q);
      if (!run_en) begin
        active <= 1'b0;
      end else if (start) begin
        active <= 1'b1;
        hc     <= '0;
        vc     <= '0;
      end else if (active) begin
        if (line_end) begin
          hc <= '0;
          vc <= last_line ? '0 : vc + CW'(1);
        end else begin
          hc <= hc + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_htot <= CW'(DEF_HTOT);
      sh_hsw  <= CW'(DEF_HSW);
      sh_hmin <= CW'(DEF_HMIN);
      sh_hmax <= CW'(DEF_HMAX);
      sh_vtot <= CW'(DEF_VTOT);
      sh_vsw  <= CW'(DEF_VSW);
      sh_vmin <= CW'(DEF_VMIN);
      sh_vmax <= CW'(DEF_VMAX);
    end else if (load) begin
      sh_htot <= cfg_htot;
      sh_hsw  <= cfg_hsw;
      sh_hmin <= cfg_hmin;
      sh_hmax <= cfg_hmax;
      sh_vtot <= cfg_vtot;
      sh_vsw  <= cfg_vsw;
      sh_vmin <= cfg_vmin;
      sh_vmax <= cfg_vmax;
    end
  end

  wire h_act = (hc >= sh_hmin) && (hc < sh_hmax);
  wire v_act = (vc >= sh_vmin) && (vc < sh_vmax);

  assign hsync = active && (hc < sh_hsw);
  assign vsync = active && (vc < sh_vsw);
  assign de    = active && h_act && v_act;
  assign s_req = de && !pat_mode;
  assign pix   = !de      ? '0 :
                 pat_mode ? pat_color :
                 s_valid  ? s_data : '0;

endmodule

// File: rtl/vid_timing_chk.sv
`timescale 1ns/1ps
module vid_timing_chk #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          run_en,
  input logic          hsync,
  input logic          vsync,
  input logic          de,
  input logic          s_req,
  input logic          active,
  input logic          pat_mode,
  input logic [CW-1:0] hc,
  input logic [CW-1:0] vc,
  input logic [CW-1:0] sh_htot,
  input logic [CW-1:0] sh_vtot
);

  // R5
  stop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> (!hsync && !vsync && !de && !s_req));

  // R1
  line_origin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hsync) |-> hc == '0);

  // R3
  line_step_chk: assert property (@(posedge clk) disable iff (rst)
    (active && $past(active) && vc != $past(vc)) |-> hc == '0);

  // R8
  frame_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    (sh_htot != $past(sh_htot) || sh_vtot != $past(sh_vtot)) |-> (hc == '0 && vc == '0));

  // R6
  pattern_noreq_chk: assert property (@(posedge clk) disable iff (rst)
    pat_mode |-> !s_req);

endmodule

bind vid_timing_gen vid_timing_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .run_en(run_en), .hsync(hsync), .vsync(vsync),
  .de(de), .s_req(s_req), .active(active), .pat_mode(pat_mode),
  .hc(hc), .vc(vc), .sh_htot(sh_htot), .sh_vtot(sh_vtot)
);

// File: tb/test_vid_timing_gen.sv
`timescale 1ns/1ps
module test_vid_timing_gen;
  localparam int CW = 12;
  localparam int PW = 16;

  typedef struct packed {
    logic [11:0] ht, hs, hmin, hmax, vt, vs, vmin, vmax;
    logic        pat;
    logic [15:0] col;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{12'd10, 12'd2, 12'd3, 12'd8,  12'd6, 12'd1, 12'd2, 12'd5, 1'b0, 16'h0000},
    '{12'd12, 12'd3, 12'd4, 12'd11, 12'd5, 12'd2, 12'd2, 12'd4, 1'b1, 16'hBEEF},
    '{12'd8,  12'd1, 12'd1, 12'd8,  12'd4, 12'd1, 12'd0, 12'd4, 1'b0, 16'h0000},
    '{12'd16, 12'd4, 12'd6, 12'd14, 12'd7, 12'd3, 12'd4, 12'd6, 1'b1, 16'h1234}
  };

  logic clk = 0, rst = 1, run_en = 0, pat_en = 0, s_valid = 0;
  logic [PW-1:0] pat_color = '0, s_data = '0;
  logic [CW-1:0] c_ht, c_hs, c_hmin, c_hmax, c_vt, c_vs, c_vmin, c_vmax;
  logic s_req, hsync, vsync, de;
  logic [PW-1:0] pix;

  int n_vec = 0, n_bad = 0, tick = 0;
  bit done = 0;
  int mhc, mvc, m_ht, m_hs, m_hmin, m_hmax, m_vt, m_vs, m_vmin, m_vmax;
  bit mrun = 0, mpat = 0;
  logic [PW-1:0] mcol;

  vid_timing_gen #(.CW(CW), .PW(PW)) i_vid_timing_gen (
    .clk(clk), .rst(rst), .run_en(run_en), .pat_en(pat_en), .pat_color(pat_color),
    .cfg_htot(c_ht), .cfg_hsw(c_hs), .cfg_hmin(c_hmin), .cfg_hmax(c_hmax),
    .cfg_vtot(c_vt), .cfg_vsw(c_vs), .cfg_vmin(c_vmin), .cfg_vmax(c_vmax),
    .s_data(s_data), .s_valid(s_valid), .s_req(s_req),
    .hsync(hsync), .vsync(vsync), .de(de), .pix(pix)
  );

  always #5 clk = ~clk;

  task automatic set_cfg(input int ht, hs, hmin, hmax, vt, vs, vmin, vmax);
    c_ht = CW'(ht); c_hs = CW'(hs); c_hmin = CW'(hmin); c_hmax = CW'(hmax);
    c_vt = CW'(vt); c_vs = CW'(vs); c_vmin = CW'(vmin); c_vmax = CW'(vmax);
  endtask

  task automatic model_load();
    m_ht = int'(c_ht); m_hs = int'(c_hs); m_hmin = int'(c_hmin); m_hmax = int'(c_hmax);
    m_vt = int'(c_vt); m_vs = int'(c_vs); m_vmin = int'(c_vmin); m_vmax = int'(c_vmax);
  endtask

  task automatic chk(input string name, input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h (h=%0d v=%0d)", req, name, act, exp, mhc, mvc);
    end
  endtask

  task automatic step(input string tag);
    bit eh, ev, ed, er;
    logic [PW-1:0] ep;
    @(negedge clk);
    tick++;
    s_valid = (tick % 5) != 2;
    s_data  = 16'h5A00 ^ 16'(tick);
    #1;
    eh = mrun && (mhc < m_hs);
    ev = mrun && (mvc < m_vs);
    ed = mrun && (mhc >= m_hmin) && (mhc < m_hmax) && (mvc >= m_vmin) && (mvc < m_vmax);
    er = ed && !mpat;
    ep = !ed ? '0 : mpat ? mcol : s_valid ? s_data : '0;
    chk("hsync", {"R1 R2", tag}, 16'(hsync), 16'(eh));
    chk("vsync", {"R3", tag}, 16'(vsync), 16'(ev));
    chk("de", {"R4", tag}, 16'(de), 16'(ed));
    chk("s_req", {mpat ? "R6" : "R7", tag}, 16'(s_req), 16'(er));
    chk("pix", {mpat ? "R6" : "R7", tag}, pix, ep);
    if (mrun) begin
      if (mhc == m_ht - 1) begin
        mhc = 0;
        if (mvc == m_vt - 1) begin
          mvc = 0;
          model_load();
        end else mvc++;
      end else mhc++;
    end
  endtask

  task automatic start_run(input bit pat);
    @(negedge clk);
    run_en = 0; pat_en = 0;
    @(negedge clk);
    run_en = 1;
    if (pat) pat_en = 1;
    model_load();
    mhc = 0; mvc = 0; mrun = 1; mpat = pat; mcol = pat_color;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    set_cfg(10, 2, 3, 8, 6, 1, 2, 5);
    run_en = 1; pat_en = 1; rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    // R5: enable level held through reset starts nothing
    repeat (6) step(" R5 reset");

    // R6: pat_en level held from reset is ignored; run_en needs a fresh rise
    @(negedge clk); run_en = 0;
    @(negedge clk); run_en = 1;
    model_load(); mhc = 0; mvc = 0; mrun = 1; mpat = 0;
    repeat (120) step(" R6 level");

    for (int i = 0; i < 4; i++) begin
      set_cfg(VECS[i].ht, VECS[i].hs, VECS[i].hmin, VECS[i].hmax,
              VECS[i].vt, VECS[i].vs, VECS[i].vmin, VECS[i].vmax);
      pat_color = VECS[i].col;
      start_run(VECS[i].pat);
      repeat (2 * int'(VECS[i].ht) * int'(VECS[i].vt)) step("");
    end

    // R8: mid-frame field change waits for the frame boundary
    set_cfg(10, 2, 3, 8, 6, 1, 2, 5);
    start_run(0);
    repeat (25) step(" R8");
    set_cfg(8, 1, 1, 8, 4, 1, 0, 4);
    repeat (95 + 64) step(" R8");

    // R10: dropping pat_en returns to stream mode
    set_cfg(12, 3, 4, 11, 5, 2, 2, 4);
    pat_color = 16'hC0DE;
    start_run(1);
    repeat (31) step(" R10");
    pat_en = 0; mpat = 0;
    repeat (40) step(" R10");

    // R5: run_en low silences all outputs on the next clock
    run_en = 0; mrun = 0;
    repeat (8) step(" R5 stop");

    // R9: 1080p raster through the first active pixels
    set_cfg(2200, 44, 192, 2112, 1125, 5, 41, 1121);
    start_run(0);
    repeat (41 * 2200 + 400) step(" R9");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule